// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. Two descriptor tables sit in on-chip registers, one global and one local. A simple write port fills them. Each entry holds a segment base, an inclusive limit and a privilege level. Six segment registers hold selectors. The kind of access picks one of them: code for fetches, stack for stack accesses, and the data register for data accesses unless the caller names another slot.

For each accepted request, the block does the following in one cycle:
- decodes the selector;
- reads the descriptor from the chosen table;
- runs the null, index range, privilege and limit checks;
- adds the base to the offset.

One clock edge later it returns either the linear address or a fault code. The requester is the only thing that drives the request port, and it may issue a new request every cycle.

Top module: `seg_xlate`

## Requirements
- R1: Each request accepted while `req_ready_o` is high (it is high whenever out of reset) produces `rsp_valid_o` high for exactly the next cycle. With no fault, `rsp_lin_o` is the descriptor base plus the offset, modulo 2^32, and `rsp_fault_o` is 0.
- R2: The selector fields are: bits [15:3] the table index, bit 2 the table select (0 global, 1 local), and bits [1:0] the requested privilege.
- R3: A selector with index 0 and table select 0 gives fault code 1 (null). Index 0 in the local table is an ordinary entry.
- R4: An index not below the table depth gives fault code 2 (range).
- R5: The effective privilege is max(current level, requested privilege), where 0 is most privileged. When the effective privilege is numerically greater than the descriptor level, the block gives fault code 3 (privilege).
- R6: An offset greater than the descriptor limit gives fault code 4 (limit). An offset equal to the limit is allowed.
- R7: Fault priority is null, then range, then privilege, then limit. Whenever a fault is reported, `rsp_lin_o` is 0.
- R8: The access kind picks the segment register as follows:
  - kind 0 (fetch) uses slot 0;
  - kind 1 (stack) uses slot 1;
  - kinds 2 and 3 (data) use slot 2, or `req_seg_i` when `req_seg_en_i` is set and `req_seg_i` is below 6.
  The override has no effect on fetch and stack accesses. Slots 6 and 7 fall back to slot 2.
- R9: A write to a segment register or a descriptor becomes visible to requests from the next cycle on. A request in the same cycle as the write sees the old value.
- R10: After reset, `rsp_valid_o` is 0, every segment register holds 0 and every descriptor is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_we_i | input | 1 | Descriptor write enable |
| desc_tbl_i | input | 1 | Table to write: 0 global, 1 local |
| desc_idx_i | input | IDX_W | Descriptor index to write |
| desc_base_i | input | 32 | Segment base |
| desc_limit_i | input | 32 | Inclusive segment limit |
| desc_dpl_i | input | 2 | Segment privilege level |
| sreg_we_i | input | 1 | Segment register write enable |
| sreg_slot_i | input | 3 | Segment register slot to write (0..5) |
| sreg_val_i | input | 16 | Selector value to write |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Request can be accepted |
| req_kind_i | input | 2 | 0 fetch, 1 stack, 2/3 data |
| req_seg_en_i | input | 1 | Use the named segment slot for a data access |
| req_seg_i | input | 3 | Named segment slot |
| req_off_i | input | 32 | Offset within the segment |
| req_cpl_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Result valid |
| rsp_lin_o | output | 32 | Linear address, 0 on fault |
| rsp_fault_o | output | 3 | 0 none, 1 null, 2 range, 3 privilege, 4 limit |

## Verification
A configuration write and a translation can land in the same cycle: a segment register write or a descriptor write together with a request that uses that register or descriptor. The bench drives both at the same clock edge. It expects the result to come from the old contents. It then repeats the request one cycle later and expects the new contents. Several checks can also fail on a single request. The bench stacks a privilege violation with a limit violation, and a null selector with a privilege violation, and judges only the code that has priority.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W    = 16;
  localparam int OFF_W    = 32;
  localparam int PL_W     = 2;
  localparam int NUM_SREG = 6;
  localparam int SLOT_W   = 3;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_NULL  = 3'd1,
    FLT_RANGE = 3'd2,
    FLT_PRIV  = 3'd3,
    FLT_LIMIT = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_DATA2 = 2'd3
  } acc_e;

  typedef struct packed {
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] limit;
    logic [PL_W-1:0]  dpl;
  } desc_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  desc_t            wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output desc_t            rdata_o
);
  desc_t ent_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[e] <= '0;
      else if (we_i && widx_i == IDX_W'(e))         ent_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < DEPTH; e++)
      if (ridx_i == IDX_W'(e)) rdata_o = ent_q[e];
  end
endmodule

// File: rtl/seg_sreg_file.sv
module seg_sreg_file
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [SEL_W-1:0]  wval_i,
  input  acc_e              kind_i,
  input  logic              ovr_en_i,
  input  logic [SLOT_W-1:0] ovr_slot_i,
  output logic [SEL_W-1:0]  sel_o
);
  localparam logic [SLOT_W-1:0] SLOT_CODE  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_STACK = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_DATA  = SLOT_W'(2);

  logic [SEL_W-1:0]  sreg_q [NUM_SREG];
  logic [SLOT_W-1:0] rslot;

  for (genvar s = 0; s < NUM_SREG; s++) begin : g_sreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               sreg_q[s] <= '0;
      else if (we_i && wslot_i == SLOT_W'(s))    sreg_q[s] <= wval_i;
    end
  end

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: rslot = SLOT_CODE;
      ACC_STACK: rslot = SLOT_STACK;
      default:   rslot = (ovr_en_i && ovr_slot_i < SLOT_W'(NUM_SREG)) ? ovr_slot_i : SLOT_DATA;
    endcase
  end

  always_comb begin
    sel_o = '0;
    for (int s = 0; s < NUM_SREG; s++)
      if (rslot == SLOT_W'(s)) sel_o = sreg_q[s];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  desc_t            desc_i,
  output fault_e           fault_o,
  output logic [OFF_W-1:0] lin_o
);
  localparam int IW = SEL_W - 3;

  logic [IW-1:0]   idx;
  logic            ti;
  logic [PL_W-1:0] rpl, eff;
  logic            in_range;

  assign idx      = sel_i[SEL_W-1:3];
  assign ti       = sel_i[2];
  assign rpl      = sel_i[1:0];
  assign eff      = (cpl_i > rpl) ? cpl_i : rpl;
  assign in_range = {{(32-IW){1'b0}}, idx} < 32'(DEPTH);

  always_comb begin
    lin_o = '0;
    if (!ti && idx == '0)           fault_o = FLT_NULL;
    else if (!in_range)             fault_o = FLT_RANGE;
    else if (eff > desc_i.dpl)      fault_o = FLT_PRIV;
    else if (off_i > desc_i.limit)  fault_o = FLT_LIMIT;
    else begin
      fault_o = FLT_NONE;
      lin_o   = desc_i.base + off_i;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_we_i,
  input  logic             desc_tbl_i,
  input  logic [IDX_W-1:0] desc_idx_i,
  input  logic [31:0]      desc_base_i,
  input  logic [31:0]      desc_limit_i,
  input  logic [1:0]       desc_dpl_i,
  input  logic             sreg_we_i,
  input  logic [2:0]       sreg_slot_i,
  input  logic [15:0]      sreg_val_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic             req_seg_en_i,
  input  logic [2:0]       req_seg_i,
  input  logic [31:0]      req_off_i,
  input  logic [1:0]       req_cpl_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_lin_o,
  output logic [2:0]       rsp_fault_o
);
  desc_t            wdesc;
  desc_t            tbl_rd [2];
  desc_t            cur_desc;
  logic [SEL_W-1:0] cur_sel;
  fault_e           chk_fault;
  logic [OFF_W-1:0] chk_lin;
  logic             rdy_q;

  assign wdesc = '{base: desc_base_i, limit: desc_limit_i, dpl: desc_dpl_i};

  seg_sreg_file u_sregs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sreg_we_i),
    .wslot_i    (sreg_slot_i),
    .wval_i     (sreg_val_i),
    .kind_i     (acc_e'(req_kind_i)),
    .ovr_en_i   (req_seg_en_i),
    .ovr_slot_i (req_seg_i),
    .sel_o      (cur_sel)
  );

  // table 0 global, table 1 local
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    seg_desc_table #(.DEPTH(TBL_DEPTH)) u_tbl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (desc_we_i && (desc_tbl_i == 1'(t))),
      .widx_i  (desc_idx_i),
      .wdata_i (wdesc),
      .ridx_i  (cur_sel[3 +: IDX_W]),
      .rdata_o (tbl_rd[t])
    );
  end

  assign cur_desc = cur_sel[2] ? tbl_rd[1] : tbl_rd[0];

  seg_check #(.DEPTH(TBL_DEPTH)) u_check (
    .sel_i   (cur_sel),
    .off_i   (req_off_i),
    .cpl_i   (req_cpl_i),
    .desc_i  (cur_desc),
    .fault_o (chk_fault),
    .lin_o   (chk_lin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end
  assign req_ready_o = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_lin_o   <= '0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && rdy_q;
      if (req_valid_i && rdy_q) begin
        rsp_lin_o   <= chk_lin;
        rsp_fault_o <= chk_fault;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_off_i,
  input logic [1:0]  req_cpl_i,
  input logic [15:0] sel_i,
  input logic [31:0] d_base_i,
  input logic [31:0] d_limit_i,
  input logic [1:0]  d_dpl_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_lin_o,
  input logic [2:0]  rsp_fault_o
);
  logic acc;
  logic [1:0] eff;
  assign acc = req_valid_i && req_ready_o;
  assign eff = (req_cpl_i > sel_i[1:0]) ? req_cpl_i : sel_i[1:0];

  p_rsp_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  p_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (rsp_fault_o != 3'd0) || (rsp_lin_o == $past(d_base_i + req_off_i)));
  p_null_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && sel_i[15:2] == 14'd0) |=> rsp_fault_o == 3'd1);
  p_priv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && eff > d_dpl_i) |=> rsp_fault_o != 3'd0);
  p_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_off_i > d_limit_i) |=> rsp_fault_o != 3'd0);
  p_zero_lin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> rsp_lin_o == 32'd0);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_off_i   (req_off_i),
  .req_cpl_i   (req_cpl_i),
  .sel_i       (cur_sel),
  .d_base_i    (cur_desc.base),
  .d_limit_i   (cur_desc.limit),
  .d_dpl_i     (cur_desc.dpl),
  .rsp_valid_o (rsp_valid_o),
  .rsp_lin_o   (rsp_lin_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  localparam int DEPTH = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_we = 0, desc_tbl = 0;
  logic [IW-1:0] desc_idx = '0;
  logic [31:0] desc_base = '0, desc_limit = '0;
  logic [1:0] desc_dpl = '0;
  logic sreg_we = 0;
  logic [2:0] sreg_slot = '0;
  logic [15:0] sreg_val = '0;
  logic req_valid = 0, req_ready, seg_en = 0;
  logic [1:0] kind = '0, cpl = '0;
  logic [2:0] seg = '0;
  logic [31:0] off = '0;
  logic rsp_valid;
  logic [31:0] rsp_lin;
  logic [2:0] rsp_fault;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  seg_xlate #(.TBL_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_we_i(desc_we), .desc_tbl_i(desc_tbl), .desc_idx_i(desc_idx),
    .desc_base_i(desc_base), .desc_limit_i(desc_limit), .desc_dpl_i(desc_dpl),
    .sreg_we_i(sreg_we), .sreg_slot_i(sreg_slot), .sreg_val_i(sreg_val),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(kind),
    .req_seg_en_i(seg_en), .req_seg_i(seg), .req_off_i(off), .req_cpl_i(cpl),
    .rsp_valid_o(rsp_valid), .rsp_lin_o(rsp_lin), .rsp_fault_o(rsp_fault)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        en;
    logic [2:0]  slot;
    logic [1:0]  cpl;
    logic [31:0] off;
    logic [2:0]  flt;
    logic [31:0] lin;
  } vec_t;

  // slots: 0=G1 rpl0, 1=G2 rpl0, 2=L0 rpl2, 3=G3 rpl3, 4=null, 5=G9 (out of range)
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,3'd0,2'd0,32'h0000_1234,3'd0,32'h1000_1234}, // R1 R8 fetch
    '{2'd0,1'b0,3'd0,2'd0,32'h0000_FFFF,3'd0,32'h1000_FFFF}, // R6 at limit
    '{2'd0,1'b0,3'd0,2'd0,32'h0001_0000,3'd4,32'h0}, // R6 over limit
    '{2'd1,1'b0,3'd0,2'd0,32'h0000_0080,3'd0,32'h2000_0080}, // R8 stack
    '{2'd1,1'b0,3'd0,2'd1,32'h0000_0080,3'd3,32'h0}, // R5 cpl1 vs dpl0
    '{2'd2,1'b0,3'd0,2'd0,32'h0000_0010,3'd0,32'h0300_0010}, // R3 local idx0, R2
    '{2'd2,1'b0,3'd0,2'd3,32'h0000_0010,3'd3,32'h0}, // R5 cpl3 > dpl2
    '{2'd3,1'b0,3'd0,2'd1,32'h0000_0010,3'd0,32'h0300_0010}, // R8 kind3 = data
    '{2'd2,1'b1,3'd3,2'd0,32'h0000_2000,3'd0,32'h0000_1000}, // R1 wrap, R5 rpl3=dpl3
    '{2'd2,1'b1,3'd4,2'd0,32'h0000_0000,3'd1,32'h0}, // R3 null
    '{2'd2,1'b1,3'd5,2'd0,32'h0000_0000,3'd2,32'h0}, // R4 range
    '{2'd0,1'b1,3'd3,2'd0,32'h0000_0010,3'd0,32'h1000_0010}, // R8 override ignored fetch
    '{2'd1,1'b1,3'd4,2'd0,32'h0000_0010,3'd0,32'h2000_0010}, // R8 override ignored stack
    '{2'd1,1'b0,3'd0,2'd3,32'h0000_1000,3'd3,32'h0}, // R7 priv over limit
    '{2'd2,1'b1,3'd4,2'd3,32'h0000_0000,3'd1,32'h0}, // R7 null over priv
    '{2'd2,1'b1,3'd5,2'd3,32'hFFFF_FFFF,3'd2,32'h0}, // R7 range over priv/limit
    '{2'd2,1'b1,3'd7,2'd0,32'h0000_0020,3'd0,32'h0300_0020}, // R8 slot7 -> data
    '{2'd2,1'b0,3'd0,2'd2,32'h0000_1000,3'd0,32'h0300_1000}, // R6 equal limit local
    '{2'd2,1'b0,3'd0,2'd2,32'h0000_1001,3'd4,32'h0}  // R6 over limit local
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wdesc(input logic t, input int i, input logic [31:0] b,
                       input logic [31:0] l, input logic [1:0] d);
    @(negedge clk);
    desc_we = 1; desc_tbl = t; desc_idx = IW'(i);
    desc_base = b; desc_limit = l; desc_dpl = d;
    @(negedge clk);
    desc_we = 0;
  endtask

  task automatic wsreg(input int s, input logic [15:0] v);
    @(negedge clk);
    sreg_we = 1; sreg_slot = 3'(s); sreg_val = v;
    @(negedge clk);
    sreg_we = 0;
  endtask

  // drive at negedge, result visible after the following posedge
  task automatic req(input logic [1:0] k, input logic e, input logic [2:0] s,
                     input logic [1:0] c, input logic [31:0] o);
    req_valid = 1; kind = k; seg_en = e; seg = s; cpl = c; off = o;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    // zero segment register -> null selector
    req(2'd2, 1'b0, 3'd0, 2'd0, 32'h10);
    chk("R10 sreg zero -> null", 32'(rsp_fault), 32'd1);
    chk("R1 valid pulse", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R1 valid drops", 32'(rsp_valid), 32'd0);
    // local idx0 zero descriptor: offset 0 ok, linear 0
    wsreg(2, 16'h0004);
    req(2'd2, 1'b0, 3'd0, 2'd0, 32'h0);
    chk("R10 zero descriptor fault", 32'(rsp_fault), 32'd0);
    req(2'd2, 1'b0, 3'd0, 2'd0, 32'h1);
    chk("R10 zero limit", 32'(rsp_fault), 32'd4);

    wdesc(1'b0, 1, 32'h1000_0000, 32'h0000_FFFF, 2'd3);
    wdesc(1'b0, 2, 32'h2000_0000, 32'h0000_00FF, 2'd0);
    wdesc(1'b0, 3, 32'hFFFF_F000, 32'hFFFF_FFFF, 2'd3);
    wdesc(1'b1, 0, 32'h0300_0000, 32'h0000_1000, 2'd2);
    wsreg(0, 16'h0008);
    wsreg(1, 16'h0010);
    wsreg(2, 16'h0006);
    wsreg(3, 16'h001B);
    wsreg(4, 16'h0000);
    wsreg(5, 16'h0048);

    for (int v = 0; v < NV; v++) begin
      req(VECS[v].kind, VECS[v].en, VECS[v].slot, VECS[v].cpl, VECS[v].off);
      chk($sformatf("R1/R8 vec %0d valid", v), 32'(rsp_valid), 32'd1);
      chk($sformatf("R3-R7 vec %0d fault", v), 32'(rsp_fault), 32'(VECS[v].flt));
      chk($sformatf("R1 vec %0d lin", v), rsp_lin, VECS[v].lin);
    end

    // R9 sreg write in same cycle as request
    sreg_we = 1; sreg_slot = 3'd2; sreg_val = 16'h000B;
    req(2'd2, 1'b0, 3'd0, 2'd0, 32'h10);
    sreg_we = 0;
    chk("R9 sreg old value", rsp_lin, 32'h0300_0010);
    req(2'd2, 1'b0, 3'd0, 2'd0, 32'h10);
    chk("R9 sreg new value", rsp_lin, 32'h1000_0010);

    // R9 descriptor write in same cycle as request
    desc_we = 1; desc_tbl = 0; desc_idx = IW'(1);
    desc_base = 32'h4000_0000; desc_limit = 32'hFFFF; desc_dpl = 2'd3;
    req(2'd0, 1'b0, 3'd0, 2'd0, 32'h0);
    desc_we = 0;
    chk("R9 desc old value", rsp_lin, 32'h1000_0000);
    req(2'd0, 1'b0, 3'd0, 2'd0, 32'h0);
    chk("R9 desc new value", rsp_lin, 32'h4000_0000);

    // R10 reset mid-run clears registers
    rst_n = 0;
    @(negedge clk);
    chk("R10 valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    req(2'd0, 1'b0, 3'd0, 2'd0, 32'h0);
    chk("R10 code reg cleared", 32'(rsp_fault), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule